// File: doc/BRIEF.md
# I2C Slave Byte Engine with Clock Stretching

This block is the target side of a two-wire serial bus. It runs on a fast system clock and oversamples the open-drain clock and data lines. It cleans both lines with a synchronizer and a majority vote, then recognises start, repeated-start and stop conditions. It frames the address byte and data bytes, and it answers on the ninth clock of each unit. The block pulls a line low only through an output enable. It never drives a line high, and it pulls the clock line only to stretch.

Each bus event that needs local attention sets a sticky event flag and publishes an 8-bit status code. These events are an address hit, a received byte, a transmitted byte, an end of transfer and a framing error. When the event falls at the end of a 9-clock unit, the clock line stays low until local logic pulses the clear input. It then stays low for a few more cycles, so that the first bit of a transmit byte has setup time. The byte to transmit is sampled at that clear. Received bytes appear on a data output when their event is raised.

Top module: `i2c_slv_stretch`

## Requirements
- R1: After reset, evt_o is 0, status_o is 0xF8, and neither scl_oe_o nor sda_oe_o is asserted.
- R2: After a START, the address byte arrives MSB first: 7 address bits, then the direction bit (1 = master reads). When the address equals own_addr_i and ack_en_i is 1, the block pulls SDA low during the ninth clock.
- R3: An acknowledged own address raises evt_o with status 0x60 for a write or 0xA8 for a read. Every status shown while evt_o is 1 is one of 0x00, 0x60, 0x70, 0x80, 0x90, 0xA0, 0xA8, 0xB8 or 0xC0.
- R4: While addressed for writing, each data byte is taken MSB first and acknowledged when ack_en_i is 1. It is then placed on rx_data_o, with status 0x80, or 0x90 when the transfer was opened by a general call.
- R5: An event raised at the end of a 9-clock unit holds SCL low from that unit's last falling edge until evt_clr_i is pulsed. The hold continues for SETUP_CYC more cycles after the clear. The clear also drops evt_o and returns status_o to 0xF8.
- R6: A STOP or repeated START that arrives during the first clock high of a unit while addressed gives status 0xA0 and does not stretch. A STOP while not addressed raises no event.
- R7: An address that is neither own_addr_i nor an enabled general call is not acknowledged and raises no event.
- R8: With gc_en_i set to 1, address 0x00 with direction 0 is acknowledged with status 0x70, and its data bytes give 0x90. With gc_en_i set to 0, the same address is not acknowledged and raises no event.
- R9: With ack_en_i set to 0, an own address or a data byte is not acknowledged and raises no event. The block then becomes unaddressed, so a following STOP raises no event.
- R10: In read mode, tx_data_i is sampled when the pending event is cleared and is sent MSB first. A master ACK on the ninth clock gives status 0xB8.
- R11: A master NACK after a sent byte gives status 0xC0. SDA is released, and the block stays unaddressed until the next START, so a following STOP raises no event.
- R12: A START or STOP while addressed, after at least one complete bit of the current unit, gives status 0x00 (bus error). The block returns to unaddressed.
- R13: A pulse of one system clock on SDA while SCL is high is not taken as a START or STOP, and it does not corrupt the byte being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Clock line as seen at the pad |
| sda_i | input | 1 | Data line as seen at the pad |
| scl_oe_o | output | 1 | Pull SCL low (stretch) |
| sda_oe_o | output | 1 | Pull SDA low (ACK or data 0) |
| own_addr_i | input | DATA_W-1 | Own 7-bit address |
| ack_en_i | input | 1 | Acknowledge address and data when 1 |
| gc_en_i | input | 1 | Respond to the general call address when 1 |
| tx_data_i | input | DATA_W | Byte to send, sampled at event clear in read mode |
| rx_data_o | output | DATA_W | Last received data byte |
| evt_clr_i | input | 1 | One-cycle pulse that clears the pending event |
| evt_o | output | 1 | Sticky event flag |
| status_o | output | 8 | Status code of the pending event, 0xF8 when none |

## Verification
The bench builds the block with its default parameters: an 8-bit unit, a two-stage synchronizer, a three-tap vote and a four-cycle release window. The bench quarter bit is 12 system clocks, so one SCL period is about 48 clocks. That is well above the 16x floor and leaves room for the filter's five-cycle delay before the master moves a line. It also lets the bench place a one-cycle SDA spike inside a clock-high phase, which reaches the vote filter directly. The four-cycle release window is long enough for the bench to confirm that SCL stays low after a clear.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_TX
  } slv_state_e;

  localparam logic [7:0] SC_BUS_ERR = 8'h00;
  localparam logic [7:0] SC_OWN_W   = 8'h60;
  localparam logic [7:0] SC_GC_W    = 8'h70;
  localparam logic [7:0] SC_RX_OWN  = 8'h80;
  localparam logic [7:0] SC_RX_GC   = 8'h90;
  localparam logic [7:0] SC_END     = 8'hA0;
  localparam logic [7:0] SC_OWN_R   = 8'hA8;
  localparam logic [7:0] SC_TX_ACK  = 8'hB8;
  localparam logic [7:0] SC_TX_NACK = 8'hC0;
  localparam logic [7:0] SC_NONE    = 8'hF8;

endpackage

// File: rtl/i2c_slv_filt.sv
module i2c_slv_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int HALF = VOTE_TAPS / 2;
  localparam int CW   = $clog2(VOTE_TAPS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   tap_q;
  logic [CW-1:0]          ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_TAPS; i++) ones = ones + CW'(tap_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      tap_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      tap_q  <= {tap_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_o <= (ones > CW'(HALF));
    end
  end
endmodule

// File: rtl/i2c_slv_cond.sv
module i2c_slv_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SCL high on both samples: data edge is a condition, not a bit
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_slv_core.sv
module i2c_slv_core
  import i2c_slv_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic              gc_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              evt_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              evt_o,
  output logic [7:0]        status_o,
  output logic              sda_drv_o,
  output logic              scl_hold_o
);
  localparam int UNIT  = DATA_W + 1;
  localparam int CNT_W = $clog2(UNIT + 1);
  localparam int REL_W = $clog2(SETUP_CYC + 1);

  slv_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, tx_q, tx_d, rx_q, rx_d;
  logic              gc_q, gc_d, mack_q, mack_d, drv_q, drv_d;
  logic              evt_q, evt_d, hold_q, hold_d;
  logic [7:0]        stat_q, stat_d;
  logic [REL_W-1:0]  rel_q, rel_d;

  logic       ev_set, ev_hold;
  logic [7:0] ev_code;
  logic       addr_own, addr_gc, in_xfer, mid_byte;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    gc_d    = gc_q;
    mack_d  = mack_q;
    drv_d   = drv_q;
    evt_d   = evt_q;
    hold_d  = hold_q;
    stat_d  = stat_q;
    rel_d   = (rel_q != '0) ? rel_q - 1'b1 : rel_q;
    ev_set  = 1'b0;
    ev_hold = 1'b0;
    ev_code = SC_NONE;

    addr_own = (sh_q[DATA_W-1:1] == own_addr_i);
    addr_gc  = gc_en_i && (sh_q[DATA_W-1:1] == '0) && !sh_q[0];
    in_xfer  = (state_q == ST_RX) || (state_q == ST_TX);
    // a legal condition only follows the first SCL rise of a unit
    mid_byte = (cnt_q >= CNT_W'(2));

    if (start_i || stop_i) begin
      if (in_xfer) begin
        ev_set  = 1'b1;
        ev_code = mid_byte ? SC_BUS_ERR : SC_END;
      end
      state_d = start_i ? ST_ADDR : ST_IDLE;
      cnt_d   = '0;
      drv_d   = 1'b0;
      gc_d    = 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise_i) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q < CNT_W'(DATA_W)) sh_d = {sh_q[DATA_W-2:0], sda_i};
        else if (state_q == ST_TX) mack_d = ~sda_i;
      end
      if (scl_fall_i) begin
        if (cnt_q == CNT_W'(DATA_W)) begin
          case (state_q)
            ST_ADDR: begin
              if (ack_en_i && (addr_own || addr_gc)) begin
                drv_d = 1'b1;
                gc_d  = !addr_own;
              end else begin
                state_d = ST_IDLE;
                cnt_d   = '0;
              end
            end
            ST_RX: begin
              if (ack_en_i) drv_d = 1'b1;
              else begin
                state_d = ST_IDLE;
                cnt_d   = '0;
              end
            end
            default: drv_d = 1'b0;
          endcase
        end else if (cnt_q == CNT_W'(UNIT)) begin
          cnt_d   = '0;
          drv_d   = 1'b0;
          ev_set  = 1'b1;
          ev_hold = 1'b1;
          case (state_q)
            ST_ADDR: begin
              if (sh_q[0]) begin
                state_d = ST_TX;
                ev_code = SC_OWN_R;
              end else begin
                state_d = ST_RX;
                ev_code = gc_q ? SC_GC_W : SC_OWN_W;
              end
            end
            ST_RX: begin
              rx_d    = sh_q;
              ev_code = gc_q ? SC_RX_GC : SC_RX_OWN;
            end
            default: begin
              ev_code = mack_q ? SC_TX_ACK : SC_TX_NACK;
              if (!mack_q) state_d = ST_IDLE;
            end
          endcase
        end else if (state_q == ST_TX && cnt_q != '0) begin
          drv_d = ~tx_q[CNT_W'(DATA_W - 1) - cnt_q];
        end
      end
    end

    if (ev_set) begin
      evt_d  = 1'b1;
      stat_d = ev_code;
      hold_d = ev_hold;
    end else if (evt_clr_i && evt_q) begin
      evt_d  = 1'b0;
      stat_d = SC_NONE;
      hold_d = 1'b0;
      if (hold_q) begin
        rel_d = REL_W'(SETUP_CYC);
        if (state_q == ST_TX && cnt_q == '0) begin
          tx_d  = tx_data_i;
          drv_d = ~tx_data_i[DATA_W-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      gc_q    <= 1'b0;
      mack_q  <= 1'b0;
      drv_q   <= 1'b0;
      evt_q   <= 1'b0;
      hold_q  <= 1'b0;
      stat_q  <= SC_NONE;
      rel_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      gc_q    <= gc_d;
      mack_q  <= mack_d;
      drv_q   <= drv_d;
      evt_q   <= evt_d;
      hold_q  <= hold_d;
      stat_q  <= stat_d;
      rel_q   <= rel_d;
    end
  end

  assign rx_data_o  = rx_q;
  assign evt_o      = evt_q;
  assign status_o   = stat_q;
  assign sda_drv_o  = drv_q;
  assign scl_hold_o = hold_q | (rel_q != '0);
endmodule

// File: rtl/i2c_slv_stretch.sv
module i2c_slv_stretch
  import i2c_slv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3,
  parameter int SETUP_CYC   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic              gc_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              evt_clr_i,
  output logic              evt_o,
  output logic [7:0]        status_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, filt;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    i2c_slv_filt #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_TAPS  (VOTE_TAPS)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  i2c_slv_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt[0]),
    .sda_i     (filt[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_slv_core #(
    .DATA_W   (DATA_W),
    .SETUP_CYC(SETUP_CYC)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .sda_i     (filt[1]),
    .own_addr_i(own_addr_i),
    .ack_en_i  (ack_en_i),
    .gc_en_i   (gc_en_i),
    .tx_data_i (tx_data_i),
    .evt_clr_i (evt_clr_i),
    .rx_data_o (rx_data_o),
    .evt_o     (evt_o),
    .status_o  (status_o),
    .sda_drv_o (sda_oe_o),
    .scl_hold_o(scl_oe_o)
  );
endmodule

// File: rtl/i2c_slv_stretch_chk.sv
module i2c_slv_stretch_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       evt_clr_i,
  input logic       evt_o,
  input logic [7:0] status_o
);
  // R5
  hold_needs_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> evt_o);

  // R5
  evt_clear_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(evt_o) |-> $past(evt_clr_i));

  // R1
  idle_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_o |-> (status_o == 8'hF8));

  // R3
  legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (status_o inside {8'h00, 8'h60, 8'h70, 8'h80, 8'h90,
                                8'hA0, 8'hA8, 8'hB8, 8'hC0}));

  // R11
  nack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && status_o == 8'hC0) |-> !sda_oe_o);

  // R6
  end_no_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && status_o == 8'hA0) |-> !scl_oe_o);
endmodule

bind i2c_slv_stretch i2c_slv_stretch_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o),
  .evt_clr_i(evt_clr_i),
  .evt_o    (evt_o),
  .status_o (status_o)
);

// File: tb/i2c_slv_stretch_bench.sv
`timescale 1ns/1ps
module i2c_slv_stretch_bench;
  localparam int Q     = 12;
  localparam int SETUP = 4;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] own_addr = OWN;
  logic ack_en = 1'b1, gc_en = 1'b0, evt_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic scl_oe, sda_oe, evt;
  logic [7:0] rx_data, status;
  wire scl_ln = scl_m & ~scl_oe;
  wire sda_ln = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int exp_q[$];
  string tag_q[$];
  logic evt_prev = 1'b0;

  always #2 clk = ~clk;

  i2c_slv_stretch u_i2c_slv_stretch (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(own_addr),
    .ack_en_i(ack_en), .gc_en_i(gc_en), .tx_data_i(tx_data),
    .rx_data_o(rx_data), .evt_clr_i(evt_clr), .evt_o(evt), .status_o(status)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // reference model: queue of expected event codes, checked on every clock
  always @(negedge clk) begin
    if (rst_n && evt && !evt_prev) begin
      if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected event", status, 'h1FF);
      else begin
        automatic int code = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(status == code[7:0], t, "event status", status, code);
      end
    end
    evt_prev = evt;
  end

  task automatic expect_evt(input int code, input string tag);
    exp_q.push_back(code);
    tag_q.push_back(tag);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic scl_up();
    int w = 0;
    scl_m = 1'b1;
    tick(1);
    while (!scl_ln && w < 20000) begin
      tick(1);
      w++;
    end
  endtask

  task automatic send_bit(input bit b, input bit glitch, output bit smp);
    sda_m = b;
    tick(Q);
    scl_up();
    tick(Q/2);
    if (glitch) begin
      sda_m = ~b;
      tick(1);
      sda_m = b;
    end
    tick(Q/2);
    smp = sda_ln;
    tick(Q);
    scl_m = 1'b0;
    tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, input int glitch_bit, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) send_bit(v[i], i == glitch_bit, s);
    send_bit(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, 1'b0, s);
      v[i] = s;
    end
    send_bit(!mack, 1'b0, s);
  endtask

  task automatic start_c();
    sda_m = 1'b1;
    tick(Q);
    scl_up();
    tick(Q);
    sda_m = 1'b0;
    tick(Q);
    scl_m = 1'b0;
    tick(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0;
    tick(Q);
    scl_up();
    tick(Q);
    sda_m = 1'b1;
    tick(2*Q);
  endtask

  task automatic serve(input logic [7:0] tx, input string tag);
    chk(evt == 1'b1, tag, "event pending before clear", evt, 1);
    tx_data = tx;
    evt_clr = 1'b1;
    tick(1);
    evt_clr = 1'b0;
    tick(1);
    chk(evt == 1'b0 && status == 8'hF8, "R5", "clear restores idle status", status, 'hF8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1
    chk(evt == 1'b0, "R1", "evt after reset", evt, 0);
    chk(status == 8'hF8, "R1", "status after reset", status, 'hF8);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "line enables after reset", {scl_oe, sda_oe}, 0);

    // R2 R3 R5: own write address
    start_c();
    expect_evt('h60, "R3");
    wr_byte({OWN, 1'b0}, -1, ack);
    chk(ack, "R2", "own address acked", ack, 1);
    chk(scl_oe == 1'b1 && scl_ln == 1'b0, "R5", "scl stretched at event", scl_oe, 1);
    tick(30);
    chk(scl_ln == 1'b0, "R5", "scl still held before clear", scl_ln, 0);
    serve(8'h00, "R3");
    chk(scl_oe == 1'b1, "R5", "scl held in release window", scl_oe, 1);
    tick(SETUP + 2);
    chk(scl_oe == 1'b0, "R5", "scl released after window", scl_oe, 0);

    // R4 data bytes
    expect_evt('h80, "R4");
    wr_byte(8'hA5, -1, ack);
    chk(ack, "R4", "data acked", ack, 1);
    chk(rx_data == 8'hA5, "R4", "rx byte", rx_data, 'hA5);
    serve(8'h00, "R4");
    // R13 spike on SDA during a high bit
    expect_evt('h80, "R13");
    wr_byte(8'h6E, 6, ack);
    chk(ack && rx_data == 8'h6E, "R13", "byte intact across spike", rx_data, 'h6E);
    serve(8'h00, "R13");

    // R6 stop while addressed
    expect_evt('hA0, "R6");
    stop_c();
    chk(evt == 1'b1 && scl_oe == 1'b0, "R6", "stop event without stretch", scl_oe, 0);
    serve(8'h00, "R6");

    // R7 foreign address
    start_c();
    wr_byte({7'h2B, 1'b0}, -1, ack);
    chk(!ack, "R7", "foreign address nacked", ack, 0);
    chk(evt == 1'b0, "R7", "no event on foreign address", evt, 0);
    stop_c();
    chk(evt == 1'b0, "R6", "no event on unaddressed stop", evt, 0);

    // R8 general call
    gc_en = 1'b1;
    start_c();
    expect_evt('h70, "R8");
    wr_byte(8'h00, -1, ack);
    chk(ack, "R8", "general call acked", ack, 1);
    serve(8'h00, "R8");
    expect_evt('h90, "R8");
    wr_byte(8'h3C, -1, ack);
    chk(ack && rx_data == 8'h3C, "R8", "general call data", rx_data, 'h3C);
    serve(8'h00, "R8");
    expect_evt('hA0, "R6");
    stop_c();
    serve(8'h00, "R6");
    gc_en = 1'b0;
    start_c();
    wr_byte(8'h00, -1, ack);
    chk(!ack && evt == 1'b0, "R8", "general call disabled nacked", ack, 0);
    stop_c();

    // R9 acknowledge disabled
    ack_en = 1'b0;
    start_c();
    wr_byte({OWN, 1'b0}, -1, ack);
    chk(!ack && evt == 1'b0, "R9", "own address nacked when disabled", ack, 0);
    stop_c();
    ack_en = 1'b1;
    start_c();
    expect_evt('h60, "R3");
    wr_byte({OWN, 1'b0}, -1, ack);
    serve(8'h00, "R3");
    ack_en = 1'b0;
    wr_byte(8'h11, -1, ack);
    chk(!ack && evt == 1'b0, "R9", "data nacked when disabled", ack, 0);
    stop_c();
    chk(evt == 1'b0, "R9", "unaddressed after nacked data", evt, 0);
    ack_en = 1'b1;

    // R10 R11 read
    start_c();
    expect_evt('hA8, "R3");
    wr_byte({OWN, 1'b1}, -1, ack);
    chk(ack, "R2", "own read address acked", ack, 1);
    serve(8'hC3, "R3");
    expect_evt('hB8, "R10");
    rd_byte(1'b1, v);
    chk(v == 8'hC3, "R10", "first sent byte", v, 'hC3);
    serve(8'h5A, "R10");
    expect_evt('hC0, "R11");
    rd_byte(1'b0, v);
    chk(v == 8'h5A, "R10", "second sent byte", v, 'h5A);
    chk(sda_oe == 1'b0, "R11", "sda released after nack", sda_oe, 0);
    serve(8'h00, "R11");
    stop_c();
    chk(evt == 1'b0, "R11", "unaddressed after nack", evt, 0);

    // R6 repeated start then read
    start_c();
    expect_evt('h60, "R3");
    wr_byte({OWN, 1'b0}, -1, ack);
    serve(8'h00, "R3");
    expect_evt('hA0, "R6");
    start_c();
    serve(8'h00, "R6");
    expect_evt('hA8, "R3");
    wr_byte({OWN, 1'b1}, -1, ack);
    serve(8'h81, "R3");
    expect_evt('hC0, "R11");
    rd_byte(1'b0, v);
    chk(v == 8'h81, "R10", "byte after repeated start", v, 'h81);
    serve(8'h00, "R11");
    stop_c();

    // R12 bus error
    start_c();
    expect_evt('h60, "R3");
    wr_byte({OWN, 1'b0}, -1, ack);
    serve(8'h00, "R3");
    begin
      bit s;
      send_bit(1'b1, 1'b0, s);
      send_bit(1'b0, 1'b0, s);
      send_bit(1'b1, 1'b0, s);
    end
    expect_evt('h00, "R12");
    stop_c();
    chk(evt == 1'b1 && status == 8'h00, "R12", "bus error code", status, 0);
    serve(8'h00, "R12");
    start_c();
    expect_evt('h60, "R12");
    wr_byte({OWN, 1'b0}, -1, ack);
    chk(ack, "R12", "recovers after bus error", ack, 1);
    serve(8'h00, "R12");
    expect_evt('hA0, "R6");
    stop_c();
    serve(8'h00, "R6");

    tick(20);
    chk(exp_q.size() == 0, "R3", "all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule